// File: doc/BRIEF.md
# Configurable-Sense GPIO Interrupt Controller

This block watches a 32-pin input port and turns activity on each pin into a latched interrupt. A 4-bit sense code per pin selects the kind of activity that counts: a rising edge, a falling edge, either edge, a high level or a low level. Detected events enter a raw pending register, but only for pins whose accept bit is set. A mask register, updated through separate set and clear addresses, then decides which pending bits reach the masked status word and the two interrupt request lines.

Software services the block with a find-first-set loop. It reads the masked status, picks the lowest set bit, clears that bit through the write-one-to-clear address and repeats until the status is zero. To change a pin's sense code, software first drops the pin's accept bit, writes the new code, clears any stale pending bit and then sets accept again. While accept is low, nothing latches for that pin.

The register port is a plain single-cycle write strobe with a combinational read. Register access is control traffic, so it has no valid/ready handshake. Pin inputs may be asynchronous and pass through a synchroniser before detection.

Top module: `gpio_sense_irq`

## Requirements
- R1: After reset the accept, mask, raw pending and masked status words and all four sense words read 0, and both request lines are low.
- R2: Pin n takes its sense code from the word at address 0x40 + 4*(n/8), bits [4*(n%8)+3 : 4*(n%8)]. Each sense word reads back the value last written to it.
- R3: Code 0x8 latches a rising edge, 0x9 a falling edge and 0xC either edge. An edge is found by comparing the synchronised input with its value one clock earlier. A pin change applied between clock edges shows in raw pending after the third rising clock edge.
- R4: Code 0xA latches while the synchronised input is high and 0xB while it is low. If the level is still active, a pending bit cleared on one clock edge is set again on the next edge.
- R5: Any other sense code, including the reset value 0, produces no detection.
- R6: The accept word at 0x14 is read/write. A pending bit can newly set only if its pin's accept bit was 1 in the previous cycle. Pending bits that are already set stay set when accept is cleared.
- R7: Writing to 0x18 sets the mask bits written as 1. Writing to 0x1C clears the mask bits written as 1. Bits written as 0 leave the mask unchanged in both cases. The mask reads back at 0x18.
- R8: Address 0x20 reads the raw pending word. Address 0x24 reads raw pending AND mask.
- R9: Writing 1s to 0x28 clears those pending bits and leaves the others alone. A clear takes priority over an event arriving in the same cycle.
- R10: irq_o[0] is the OR of masked status bits 0 to 15, and irq_o[1] is the OR of bits 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Pin levels, may be asynchronous |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Byte address of the read |
| rd_data_o | output | 32 | Combinational read data, 0 for unused addresses |
| irq_o | output | 2 | Interrupt requests for the lower and upper pin halves |

## Verification
The bench aims at several corner cases, each of which a wrong design would show clearly:
- Level re-assertion right after a clear: a design that lets the clear hold, or that lets the event win over the clear, gives the wrong bit on the very next cycle.
- Sense fields placed in the wrong word or nibble: these light up a neighbouring pin, or no pin at all.
- The accept gate: a design that gates the wrong way latches events while the pin is closed, or drops bits that were already pending when accept falls.
- Write-1 mask updates: zero bits that are not ignored corrupt other pins' enables.
- Unused sense codes: these must stay silent.
- Random rounds: these pair every sense code with every before/after level pair and check raw pending, masked status and the correct request line together.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
  localparam int SENSE_W = 4;

  typedef enum logic [SENSE_W-1:0] {
    SNS_OFF  = 4'h0,
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  localparam logic [7:0] ADR_ACCEPT = 8'h14;
  localparam logic [7:0] ADR_MSET   = 8'h18;
  localparam logic [7:0] ADR_MCLR   = 8'h1C;
  localparam logic [7:0] ADR_RAW    = 8'h20;
  localparam logic [7:0] ADR_STAT   = 8'h24;
  localparam logic [7:0] ADR_PCLR   = 8'h28;
  localparam logic [7:0] ADR_SENSE  = 8'h40;
endpackage

// File: rtl/gsi_sync.sv
module gsi_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gsi_detect.sv
module gsi_detect
  import gsi_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         lvl,
  input  logic [NPINS*SENSE_W-1:0] sense,
  output logic [NPINS-1:0]         evt
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SENSE_W-1:0] code;
    assign code = sense[i*SENSE_W +: SENSE_W];
    always_comb begin
      case (code)
        SNS_RISE: evt[i] =  lvl[i] & ~prev_q[i];
        SNS_FALL: evt[i] = ~lvl[i] &  prev_q[i];
        SNS_HIGH: evt[i] =  lvl[i];
        SNS_LOW:  evt[i] = ~lvl[i];
        SNS_BOTH: evt[i] =  lvl[i] ^  prev_q[i];
        default:  evt[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gsi_regs.sv
module gsi_regs
  import gsi_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [7:0]               rd_addr,
  input  logic [NPINS-1:0]         evt,
  output logic [WORD_W-1:0]        rd_data,
  output logic [NPINS-1:0]         acc,
  output logic [NPINS-1:0]         mask,
  output logic [NPINS-1:0]         pend,
  output logic [NPINS-1:0]         stat,
  output logic [NPINS*SENSE_W-1:0] sense
);
  localparam int FIELDS = WORD_W / SENSE_W;
  localparam int NWORDS = (NPINS + FIELDS - 1) / FIELDS;

  logic [WORD_W-1:0] sense_q [NWORDS];
  logic [NPINS-1:0]  wbits, pclr;

  assign wbits = wr_data[NPINS-1:0];
  assign pclr  = (wr_en && wr_addr == ADR_PCLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      mask <= '0;
      pend <= '0;
      for (int w = 0; w < NWORDS; w++) sense_q[w] <= '0;
    end else begin
      if (wr_en && wr_addr == ADR_ACCEPT) acc <= wbits;
      if (wr_en && wr_addr == ADR_MSET)      mask <= mask | wbits;
      else if (wr_en && wr_addr == ADR_MCLR) mask <= mask & ~wbits;
      pend <= (pend | (evt & acc)) & ~pclr;
      for (int w = 0; w < NWORDS; w++)
        if (wr_en && wr_addr == ADR_SENSE + 8'(4 * w)) sense_q[w] <= wr_data;
    end
  end

  assign stat = pend & mask;

  for (genvar w = 0; w < NWORDS; w++) begin : g_flat
    localparam int HI = ((w + 1) * WORD_W > NPINS * SENSE_W) ? NPINS * SENSE_W : (w + 1) * WORD_W;
    assign sense[HI-1 : w*WORD_W] = sense_q[w][HI-w*WORD_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_ACCEPT: rd_data = WORD_W'(acc);
      ADR_MSET:   rd_data = WORD_W'(mask);
      ADR_RAW:    rd_data = WORD_W'(pend);
      ADR_STAT:   rd_data = WORD_W'(stat);
      default:    ;
    endcase
    for (int w = 0; w < NWORDS; w++)
      if (rd_addr == ADR_SENSE + 8'(4 * w)) rd_data = sense_q[w];
  end
endmodule

// File: rtl/gpio_sense_irq.sv
module gpio_sense_irq
  import gsi_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int NLINES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [NLINES-1:0] irq_o
);
  localparam int PER_LINE = NPINS / NLINES;

  logic [NPINS-1:0]         lvl, evt, acc_q, mask_q, pend_q, stat;
  logic [NPINS*SENSE_W-1:0] sense_flat;

  gsi_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(lvl)
  );

  gsi_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .sense(sense_flat), .evt(evt)
  );

  gsi_regs #(.NPINS(NPINS), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_addr(rd_addr_i), .evt(evt), .rd_data(rd_data_o),
    .acc(acc_q), .mask(mask_q), .pend(pend_q), .stat(stat), .sense(sense_flat)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    assign irq_o[l] = |stat[l*PER_LINE +: PER_LINE];
  end
endmodule

// File: rtl/gsi_chk.sv
module gsi_chk #(
  parameter int NPINS = 32,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en_i,
  input logic [7:0]          wr_addr_i,
  input logic [WORD_W-1:0]   wr_data_i,
  input logic [NPINS-1:0]    acc_q,
  input logic [NPINS-1:0]    mask_q,
  input logic [NPINS-1:0]    pend_q,
  input logic [NPINS*4-1:0]  sense_flat,
  input logic [1:0]          irq_o
);
  AST_PCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 8'h28) |=> ((pend_q & $past(wr_data_i[NPINS-1:0])) == '0)); // R9

  AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(acc_q)) == '0)); // R6

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 8'h18) |=> ((mask_q & $past(wr_data_i[NPINS-1:0])) == $past(wr_data_i[NPINS-1:0]))); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 8'h1C) |=> ((mask_q & $past(wr_data_i[NPINS-1:0])) == '0)); // R7

  AST_IRQ_LO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == |(pend_q[NPINS/2-1:0] & mask_q[NPINS/2-1:0])); // R10

  AST_IRQ_HI: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[1] == |(pend_q[NPINS-1:NPINS/2] & mask_q[NPINS-1:NPINS/2])); // R10

  for (genvar i = 0; i < NPINS; i++) begin : g_off
    AST_NO_SENSE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !$past(pend_q[i])) |->
        ($past(sense_flat[i*4 +: 4]) >= 4'h8 && $past(sense_flat[i*4 +: 4]) <= 4'hC)); // R5
  end
endmodule

bind gpio_sense_irq gsi_chk #(.NPINS(NPINS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .acc_q(acc_q), .mask_q(mask_q), .pend_q(pend_q),
  .sense_flat(sense_flat), .irq_o(irq_o)
);

// File: tb/gpio_sense_irq_tb.sv
`timescale 1ns/1ps
module gpio_sense_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  gpio_sense_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit lvl_hit(logic [3:0] c, bit b);
    return (c == 4'hA && b) || (c == 4'hB && !b);
  endfunction

  function automatic bit exp_hit(logic [3:0] c, bit b0, bit b1);
    bit edge_hit;
    edge_hit = (c == 4'h8 && !b0 && b1) || (c == 4'h9 && b0 && !b1) || (c == 4'hC && b0 != b1);
    return edge_hit || lvl_hit(c, b0) || lvl_hit(c, b1);
  endfunction

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0] codes [7] = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'h0, 4'h3};
    void'($urandom(32'h5EED_0042));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    rd(8'h14, v); check("R1 accept", v, 0);
    rd(8'h18, v); check("R1 mask", v, 0);
    rd(8'h20, v); check("R1 raw", v, 0);
    rd(8'h24, v); check("R1 status", v, 0);
    for (int w = 0; w < 4; w++) begin
      rd(8'h40 + 8'(4 * w), v); check("R1 sense", v, 0);
    end
    check("R1 irq", 32'(irq), 0);

    // R2: pin 9 -> word 0x44 nibble 1, high level
    wr(8'h44, 32'h0000_00A0);
    rd(8'h44, v); check("R2 readback", v, 32'h0000_00A0);
    wr(8'h14, 32'h0000_0200);
    pins[9] = 1'b1;
    idle(5);
    rd(8'h20, v); check("R2 R4 pin9 high", v, 32'h0000_0200);

    // R9 then R4: clear wins, level re-asserts next edge
    wr(8'h28, 32'h0000_0200);
    rd(8'h20, v); check("R9 cleared", v, 0);
    idle(1);
    rd(8'h20, v); check("R4 reassert", v, 32'h0000_0200);
    pins[9] = 1'b0;
    idle(4);
    wr(8'h28, 32'h0000_0200);
    idle(2);
    rd(8'h20, v); check("R4 level gone", v, 0);

    // R6: accept gate
    wr(8'h14, 32'h0);
    rd(8'h14, v); check("R6 accept readback", v, 0);
    pins[9] = 1'b1;
    idle(5);
    rd(8'h20, v); check("R6 gated", v, 0);
    wr(8'h14, 32'h0000_0200);
    idle(1);
    wr(8'h14, 32'h0);
    idle(2);
    rd(8'h20, v); check("R6 held", v, 32'h0000_0200);
    pins[9] = 1'b0;
    wr(8'h44, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);

    // R5: unused code 0x5 on pin 3, code 0 on pin 4
    wr(8'h40, 32'h0000_5000);
    wr(8'h14, 32'hFFFF_FFFF);
    pins[3] = 1'b1; pins[4] = 1'b1;
    idle(5);
    pins[3] = 1'b0; pins[4] = 1'b0;
    idle(5);
    rd(8'h20, v); check("R5 no detect", v, 0);
    wr(8'h14, 32'h0);
    wr(8'h40, 32'h0);

    // R7: mask set/clear with zero bits ignored
    wr(8'h18, 32'h0000_00F0);
    wr(8'h18, 32'h0000_0003);
    rd(8'h18, v); check("R7 set", v, 32'h0000_00F3);
    wr(8'h1C, 32'h0000_0030);
    rd(8'h18, v); check("R7 clear", v, 32'h0000_00C3);
    wr(8'h1C, 32'hFFFF_FFFF);

    // R8 R10 R3: pin 20 rising edge -> upper line
    wr(8'h48, 32'h0008_0000);
    wr(8'h14, 32'h0010_0000);
    pins[20] = 1'b1;
    idle(5);
    rd(8'h20, v); check("R3 rise pin20", v, 32'h0010_0000);
    rd(8'h24, v); check("R8 masked off", v, 0);
    check("R10 irq off", 32'(irq), 0);
    wr(8'h18, 32'h0010_0000);
    rd(8'h24, v); check("R8 status", v, 32'h0010_0000);
    check("R10 upper line", 32'(irq), 32'h2);
    wr(8'h28, 32'h0010_0000);
    idle(1);
    check("R10 after clear", 32'(irq), 0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0);
    wr(8'h48, 32'h0);
    pins = '0;
    idle(4);

    // Random rounds: R3 R4 R5 R8 R10
    for (int r = 0; r < 48; r++) begin
      int k;
      logic [3:0] c;
      bit b0, b1, m, e;
      logic [31:0] kb;
      k  = $urandom_range(31, 0);
      c  = codes[$urandom_range(6, 0)];
      b0 = 1'($urandom_range(1, 0));
      b1 = 1'($urandom_range(1, 0));
      m  = 1'($urandom_range(1, 0));
      kb = 32'h1 << k;
      wr(8'h14, 32'h0);
      wr(8'h40 + 8'(4 * (k / 8)), 32'(c) << (4 * (k % 8)));
      pins[k] = b0;
      idle(5);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h14, kb);
      idle(4);
      rd(8'h20, v); check("R4 R5 random initial level", v, lvl_hit(c, b0) ? kb : 0);
      wr(8'h28, 32'hFFFF_FFFF);
      pins[k] = b1;
      idle(5);
      e = exp_hit(c, b0, b1);
      rd(8'h20, v); check("R3 R4 R5 random raw", v, e ? kb : 0);
      if (m) wr(8'h18, kb);
      rd(8'h24, v); check("R8 random status", v, (e && m) ? kb : 0);
      check("R10 random irq", 32'(irq), (e && m) ? (k < 16 ? 32'h1 : 32'h2) : 0);
      wr(8'h1C, 32'hFFFF_FFFF);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule